// File: doc/BRIEF.md
# Dual-Direction Mailbox Exchange

This block gives two ports, each on its own free-running clock, a path for passing single words to each other outside the main FIFO. There is one holding register per direction. The forward register carries a word from port A to port B, and the return register carries a word from port B to port A. Each register has an active-low full flag in the writer's clock domain. The flag drops on the edge that stores a word. It rises again only after the reader has taken the word and that acknowledge has crossed back into the writer's domain.

Each port uses plain synchronous controls: chip select (active low), enable, write/read direction and a mailbox select. Data moves on a rising edge only when the port is selected, enabled and mailbox select is high. The block has no valid/ready handshake. The full flag is the writer's only back-pressure. A write made while the flag is low is dropped, so the writer has to wait for the flag to go high before it writes again. On port B the read data comes from the forward mailbox when mailbox select is high, and from the FIFO output register, which is supplied from outside, when mailbox select is low. Port A's read data always shows the return mailbox.

The two domains exchange toggle events through synchronizer chains. The mail word itself does not pass through a synchronizer. It is only read after its toggle has been synchronized, and it cannot change while it is unread.

Top module: `mailbox_pair`

## Requirements
- R1: While reset is asserted and after it is released, both full flags are high (1 means empty) and both mailbox registers read as zero.
- R2: A port-A access with a_cs_n=0, a_en=1, a_wr=1 and a_mbox=1 while a2b_full_n=1 stores a_wdata in the forward mailbox, and a2b_full_n is low right after that clk_a edge.
- R3: While a2b_full_n is low, a port-A mailbox write leaves the forward mailbox contents unchanged. The same holds for b2a_full_n and port-B writes.
- R4: A port-B mailbox read (b_cs_n=0, b_en=1, b_wr=0, b_mbox=1) of unread mail makes a2b_full_n return high within a few clk_a cycles. After that, the next port-A mailbox write is accepted.
- R5: The return direction mirrors R2 to R4. A port-B mailbox write fills the return mailbox and drops b2a_full_n, and a port-A mailbox read releases b2a_full_n.
- R6: b_rdata shows the forward mailbox when b_mbox=1 and fifo_q when b_mbox=0. a_rdata always shows the return mailbox.
- R7: An access with chip select high or enable low neither writes a mailbox nor releases a flag.
- R8: A mailbox read made while no unread mail is present returns the old contents and leaves both flags high.
- R9: A port write with mailbox select low leaves the mailbox contents and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous reset, active low, for both domains |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_en | input | 1 | Port A enable |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_mbox | input | 1 | Port A mailbox select |
| a_wdata | input | 36 | Port A write data |
| a_rdata | output | 36 | Return mailbox contents |
| a2b_full_n | output | 1 | Forward mailbox flag in the clk_a domain, low while mail is unread |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_en | input | 1 | Port B enable |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_mbox | input | 1 | Port B mailbox select |
| b_wdata | input | 36 | Port B write data |
| fifo_q | input | 36 | FIFO output register, routed to b_rdata when b_mbox=0 |
| b_rdata | output | 36 | Port B read data |
| b2a_full_n | output | 1 | Return mailbox flag in the clk_b domain, low while mail is unread |

## Verification
A lost or doubled toggle shows up at the ports as a flag that never rises again or never falls. That fault is visible within a few clock cycles of the access that caused it. A write-protect fault shows up as a changed word on the reader's data bus, seen on the next read after a second write. Each vector therefore waits a fixed settle time that is longer than the two synchronizer round trips, then compares both flags and both mail words. The falling edge of a flag is also checked on the cycle right after the write.

// File: rtl/mailbox_pkg.sv
package mailbox_pkg;
  localparam int unsigned MAIL_W_DEF = 36;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef struct packed {
    logic cs_n;
    logic en;
    logic wr;
    logic mbox;
  } port_ctl_t;

  function automatic logic mbox_write(port_ctl_t c);
    return !c.cs_n && c.en && c.wr && c.mbox;
  endfunction

  function automatic logic mbox_read(port_ctl_t c);
    return !c.cs_n && c.en && !c.wr && c.mbox;
  endfunction
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int unsigned WIDTH = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wdata,
  output logic             full_n,
  input  logic             rd_req,
  output logic [WIDTH-1:0] mail_q
);
  logic wr_tog, ack_tog, ack_seen, wr_seen, pending;

  // writer domain: store, toggle, and see the acknowledge come back
  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      mail_q <= '0;
      wr_tog <= 1'b0;
    end else if (wr_req && full_n) begin
      mail_q <= wdata;
      wr_tog <= ~wr_tog;
    end
  end

  mbx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(wclk), .rst_n(rst_n), .d(ack_tog), .q(ack_seen)
  );

  assign full_n = (wr_tog == ack_seen);

  // reader domain: learn of new mail, acknowledge on a mailbox read
  mbx_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(rclk), .rst_n(rst_n), .d(wr_tog), .q(wr_seen)
  );

  assign pending = (wr_seen != ack_tog);

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)                 ack_tog <= 1'b0;
    else if (rd_req && pending) ack_tog <= ~ack_tog;
  end

  assert_flag_drop_R2: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_req && full_n) |=> !full_n);
  assert_write_protect_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(mail_q));
  assert_ack_clears_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_req && pending) |=> !pending);
  assert_no_spurious_R7: assert property (@(posedge wclk) disable iff (!rst_n)
    (full_n && !wr_req) |=> full_n);
  assert_stale_read_R8: assert property (@(posedge rclk) disable iff (!rst_n)
    (!pending && rd_req) |=> $stable(ack_tog));
endmodule

// File: rtl/mailbox_pair.sv
module mailbox_pair
  import mailbox_pkg::*;
#(
  parameter int unsigned MAIL_W = MAIL_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst_n,
  input  logic              a_cs_n,
  input  logic              a_en,
  input  logic              a_wr,
  input  logic              a_mbox,
  input  logic [MAIL_W-1:0] a_wdata,
  output logic [MAIL_W-1:0] a_rdata,
  output logic              a2b_full_n,
  input  logic              b_cs_n,
  input  logic              b_en,
  input  logic              b_wr,
  input  logic              b_mbox,
  input  logic [MAIL_W-1:0] b_wdata,
  input  logic [MAIL_W-1:0] fifo_q,
  output logic [MAIL_W-1:0] b_rdata,
  output logic              b2a_full_n
);
  port_ctl_t ctl_a, ctl_b;
  logic [MAIL_W-1:0] fwd_q, ret_q;

  assign ctl_a = '{cs_n: a_cs_n, en: a_en, wr: a_wr, mbox: a_mbox};
  assign ctl_b = '{cs_n: b_cs_n, en: b_en, wr: b_wr, mbox: b_mbox};

  mbx_channel #(.WIDTH(MAIL_W), .SYNC_STAGES(SYNC_STAGES)) u_fwd (
    .wclk(clk_a), .rclk(clk_b), .rst_n(rst_n),
    .wr_req(mbox_write(ctl_a)), .wdata(a_wdata), .full_n(a2b_full_n),
    .rd_req(mbox_read(ctl_b)), .mail_q(fwd_q)
  );

  mbx_channel #(.WIDTH(MAIL_W), .SYNC_STAGES(SYNC_STAGES)) u_ret (
    .wclk(clk_b), .rclk(clk_a), .rst_n(rst_n),
    .wr_req(mbox_write(ctl_b)), .wdata(b_wdata), .full_n(b2a_full_n),
    .rd_req(mbox_read(ctl_a)), .mail_q(ret_q)
  );

  assign b_rdata = b_mbox ? fwd_q : fifo_q;
  assign a_rdata = ret_q;
endmodule

// File: tb/mailbox_pair_bench.sv
module mailbox_pair_bench;
  localparam int W = 36;
  localparam int SETTLE = 10;

  logic clk_a = 0, clk_b = 0, rst_n = 0;
  logic a_cs_n = 1, a_en = 0, a_wr = 0, a_mbox = 0;
  logic b_cs_n = 1, b_en = 0, b_wr = 0, b_mbox = 1;
  logic [W-1:0] a_wdata = '0, b_wdata = '0, fifo_q = '0;
  logic [W-1:0] a_rdata, b_rdata;
  logic a2b_full_n, b2a_full_n;
  int total = 0, bad = 0;

  always #5 clk_a = ~clk_a;
  initial begin #3; forever #5 clk_b = ~clk_b; end

  mailbox_pair u_mailbox_pair (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .a_cs_n(a_cs_n), .a_en(a_en), .a_wr(a_wr), .a_mbox(a_mbox),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a2b_full_n(a2b_full_n),
    .b_cs_n(b_cs_n), .b_en(b_en), .b_wr(b_wr), .b_mbox(b_mbox),
    .b_wdata(b_wdata), .fifo_q(fifo_q), .b_rdata(b_rdata),
    .b2a_full_n(b2a_full_n)
  );

  // kind: 0 A mailbox write, 1 B mailbox read, 2 B mailbox write, 3 A mailbox read
  typedef struct packed {
    logic [1:0]   kind;
    logic         cs_n;
    logic         en;
    logic [W-1:0] data;
    logic [W-1:0] exp_fwd;
    logic [W-1:0] exp_ret;
    logic         exp_f1;
    logic         exp_f2;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b1, 36'h1_2345_6789, 36'h1_2345_6789, 36'h0, 1'b0, 1'b1}, // R2
    '{2'd0, 1'b0, 1'b1, 36'hA_AAAA_5555, 36'h1_2345_6789, 36'h0, 1'b0, 1'b1}, // R3
    '{2'd1, 1'b0, 1'b1, 36'h0,           36'h1_2345_6789, 36'h0, 1'b1, 1'b1}, // R4
    '{2'd0, 1'b1, 1'b1, 36'h3_3333_3333, 36'h1_2345_6789, 36'h0, 1'b1, 1'b1}, // R7
    '{2'd0, 1'b0, 1'b0, 36'h3_3333_3333, 36'h1_2345_6789, 36'h0, 1'b1, 1'b1}, // R7
    '{2'd0, 1'b0, 1'b1, 36'hF_0F0F_0F0F, 36'hF_0F0F_0F0F, 36'h0, 1'b0, 1'b1}, // R4
    '{2'd2, 1'b0, 1'b1, 36'h8_7654_3210, 36'hF_0F0F_0F0F, 36'h8_7654_3210, 1'b0, 1'b0}, // R5
    '{2'd2, 1'b0, 1'b1, 36'h5_5555_AAAA, 36'hF_0F0F_0F0F, 36'h8_7654_3210, 1'b0, 1'b0}, // R3
    '{2'd3, 1'b1, 1'b1, 36'h0,           36'hF_0F0F_0F0F, 36'h8_7654_3210, 1'b0, 1'b0}, // R7
    '{2'd3, 1'b0, 1'b1, 36'h0,           36'hF_0F0F_0F0F, 36'h8_7654_3210, 1'b0, 1'b1}, // R5
    '{2'd1, 1'b0, 1'b1, 36'h0,           36'hF_0F0F_0F0F, 36'h8_7654_3210, 1'b1, 1'b1}, // R4
    '{2'd1, 1'b0, 1'b1, 36'h0,           36'hF_0F0F_0F0F, 36'h8_7654_3210, 1'b1, 1'b1}, // R8
    '{2'd3, 1'b0, 1'b1, 36'h0,           36'hF_0F0F_0F0F, 36'h8_7654_3210, 1'b1, 1'b1}  // R8
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op_a(input logic cs_n, input logic en, input logic wr,
                      input logic mbox, input logic [W-1:0] d);
    @(negedge clk_a);
    a_cs_n = cs_n; a_en = en; a_wr = wr; a_mbox = mbox; a_wdata = d;
    @(negedge clk_a);
    a_cs_n = 1; a_en = 0; a_wr = 0; a_mbox = 0;
  endtask

  task automatic op_b(input logic cs_n, input logic en, input logic wr,
                      input logic mbox, input logic [W-1:0] d);
    @(negedge clk_b);
    b_cs_n = cs_n; b_en = en; b_wr = wr; b_mbox = mbox; b_wdata = d;
    @(negedge clk_b);
    b_cs_n = 1; b_en = 0; b_wr = 0; b_mbox = 1;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk_a);
    @(negedge clk_b);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_a);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_a);
    chk("R1 f1 in reset", W'(a2b_full_n), W'(1));
    chk("R1 f2 in reset", W'(b2a_full_n), W'(1));
    rst_n = 1;
    settle();
    chk("R1 f1", W'(a2b_full_n), W'(1));
    chk("R1 f2", W'(b2a_full_n), W'(1));
    chk("R1 fwd", b_rdata, '0);
    chk("R1 ret", a_rdata, '0);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].kind)
        2'd0: op_a(VECS[i].cs_n, VECS[i].en, 1'b1, 1'b1, VECS[i].data);
        2'd1: op_b(VECS[i].cs_n, VECS[i].en, 1'b0, 1'b1, VECS[i].data);
        2'd2: op_b(VECS[i].cs_n, VECS[i].en, 1'b1, 1'b1, VECS[i].data);
        default: op_a(VECS[i].cs_n, VECS[i].en, 1'b0, 1'b1, VECS[i].data);
      endcase
      settle();
      chk($sformatf("R2-vec%0d fwd", i), b_rdata, VECS[i].exp_fwd);
      chk($sformatf("R5 vec%0d ret", i), a_rdata, VECS[i].exp_ret);
      chk($sformatf("R4 vec%0d f1", i), W'(a2b_full_n), W'(VECS[i].exp_f1));
      chk($sformatf("R5 vec%0d f2", i), W'(b2a_full_n), W'(VECS[i].exp_f2));
    end

    // R2: flag low right after the storing edge
    @(negedge clk_a);
    a_cs_n = 0; a_en = 1; a_wr = 1; a_mbox = 1; a_wdata = 36'hC_0FFE_E000;
    @(negedge clk_a);
    a_cs_n = 1; a_en = 0; a_wr = 0; a_mbox = 0;
    chk("R2 immediate drop", W'(a2b_full_n), W'(0));
    settle();
    chk("R2 stored", b_rdata, 36'hC_0FFE_E000);

    // R6: port B read mux
    @(negedge clk_b);
    fifo_q = 36'h7_1234_ABCD; b_mbox = 0;
    #1 chk("R6 fifo path", b_rdata, 36'h7_1234_ABCD);
    b_mbox = 1;
    #1 chk("R6 mail path", b_rdata, 36'hC_0FFE_E000);

    // R9: write with mailbox select low does nothing
    op_b(1'b0, 1'b1, 1'b1, 1'b0, 36'h9_9999_9999);
    settle();
    chk("R9 ret unchanged", a_rdata, 36'h8_7654_3210);
    chk("R9 f2 unchanged", W'(b2a_full_n), W'(1));

    // R1: reset while mail pending
    @(negedge clk_a); rst_n = 0;
    @(negedge clk_a);
    chk("R1 reset f1", W'(a2b_full_n), W'(1));
    chk("R1 reset fwd", b_rdata, '0);
    rst_n = 1;
    settle();
    chk("R1 after f1", W'(a2b_full_n), W'(1));

    finish_run();
  end
endmodule